// File: doc/BRIEF.md
# Single-Precision to 8-bit E4M3 Float Narrowing Converter

This block takes a 32-bit IEEE single-precision bit pattern and produces the closest 8-bit E4M3 value: one sign bit, a four-bit exponent with bias 7 and a three-bit fraction. The 8-bit format has no infinity. Its only not-a-number encoding is the code with every exponent and fraction bit set, and that code also stands for any magnitude too large to represent. Rounding is always to nearest, with ties going to the code whose lowest bit is zero.

A sample arrives with an input strobe. The converted byte appears with an output strobe on the following clock. The conversion itself is combinational: sign split and range classification, a normal-range rounder, a subnormal-range rounder and a final select. A single register stage follows it. When the input strobe is low the output register keeps its previous byte. Typical use is as the narrowing step at the end of a datapath that stores activations or weights in the compact format.

Top module: `fp32_to_e4m3_cvt`

## Requirements
- R1: Output bit 7 of every converted byte equals input bit 31, for every input including zeros, overflows and not-a-number inputs.
- R2: When input bits 30:0, read as an unsigned number, are at least 0x43F00000 (480.0, which covers all infinities and not-a-number inputs), output bits 6:0 are 0x7F.
- R3: Magnitudes from 2^-6 (bits 30:0 at least 0x3C800000) up to below 480 are rounded to nearest with ties to even. The output exponent field is bits 6:3 and equals the input exponent minus 120; the fraction field is bits 2:0. For example, 1.0 (0x3F800000) gives 0x38, 1.0625 gives 0x38, 1.1875 gives 0x3A and 448.0 gives 0x7E.
- R4: A round-up that overflows the 3-bit fraction carries into the exponent field. For example, 1.9375 gives 0x40 and exactly 464.0 gives 0x7E. Any magnitude strictly between 464 and 480 gives 0x7F.
- R5: Magnitudes below 2^-6 are expressed as a count of 2^-9 steps and rounded to nearest with ties to even. The count is placed in bits 6:0, where 0x08 is the smallest normal value. For example, 7.5 steps gives 0x08, 6.5 steps gives 0x06 and 1.5 steps gives 0x02.
- R6: Magnitudes at or below 2^-10 give magnitude 0, while a magnitude just above 2^-10 gives 0x01. Input 0x00000000 gives 0x00, input 0x80000000 gives 0x80, and single-precision subnormal inputs give a zero magnitude.
- R7: The output byte changes only on a clock edge where the input strobe is high. Otherwise it holds its previous value.
- R8: The output strobe equals the input strobe delayed by one clock. A synchronous reset clears both the output strobe and the output byte to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Input sample strobe |
| in_bits_i | input | 32 | Single-precision input bit pattern |
| out_valid_o | output | 1 | Output strobe, one clock after in_valid_i |
| out_bits_o | output | 8 | E4M3 result byte |

## Verification
The bound checker checks several properties on every cycle: the strobe delay and its reset, the hold of the output byte on idle cycles, sign propagation, the forced 0x7F magnitude for large inputs and the zero result for zero inputs. It also checks that results from the normal path never fall below code 0x08 and that results from the subnormal path never exceed it. The exact rounding decisions can only be shown by the bench scenarios. These are the tie cases in both ranges, the carry into the exponent, the split between 464 and 480, the 2^-10 underflow boundary and a broad sweep of exponents and fraction patterns. The bench compares all of them against a nearest-code search.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    // Input and output format description
    localparam int IN_EXP_W  = 8;
    localparam int IN_MAN_W  = 23;
    localparam int IN_BIAS   = 127;
    localparam int OUT_EXP_W = 4;
    localparam int OUT_MAN_W = 3;
    localparam int OUT_BIAS  = 7;

    // Derived widths
    localparam int IN_W      = 1 + IN_EXP_W + IN_MAN_W;
    localparam int MAG_IN_W  = IN_W - 1;
    localparam int OUT_W     = 1 + OUT_EXP_W + OUT_MAN_W;
    localparam int OUT_MAG_W = OUT_W - 1;
    localparam int SIG_W     = IN_MAN_W + 1;
    localparam int DROP_W    = IN_MAN_W - OUT_MAN_W;

    // Exponent relations
    localparam int REBIAS       = IN_BIAS - OUT_BIAS;
    localparam int MIN_NORM_EXP = REBIAS + 1;
    // right shift of the full significand that leaves whole 2^-9 steps
    localparam int SUB_BASE     = IN_BIAS + IN_MAN_W - (OUT_BIAS - 1 + OUT_MAN_W);
    localparam int SH_W         = $clog2(SUB_BASE + 1) + 1;
    localparam int OVF_EXP      = (2**OUT_EXP_W - 1) - OUT_BIAS + IN_BIAS;

    // Magnitude thresholds on the raw input bits
    localparam logic [MAG_IN_W-1:0] OVF_LIMIT =
        {IN_EXP_W'(OVF_EXP), IN_MAN_W'((2**OUT_MAN_W - 1) << DROP_W)};
    localparam logic [MAG_IN_W-1:0] SUB_LIMIT =
        {IN_EXP_W'(MIN_NORM_EXP), IN_MAN_W'(0)};
    localparam logic [OUT_MAG_W-1:0] NAN_MAG = '1;

    typedef struct packed {
        logic                sign;
        logic                ovf;
        logic                sub;
        logic [IN_EXP_W-1:0] exp;
        logic [IN_MAN_W-1:0] man;
    } split_t;

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] bits;
    } stage_t;

endpackage

// File: rtl/cvt_rne_step.sv
module cvt_rne_step #(
    parameter int W = 7
) (
    input  logic [W-1:0] kept_i,
    input  logic         guard_i,
    input  logic         sticky_i,
    output logic [W-1:0] rounded_o
);
    logic bump;

    always_comb begin
        // round up above half, or at exactly half when the kept value is odd
        bump      = guard_i & (sticky_i | kept_i[0]);
        rounded_o = kept_i + W'(bump);
    end
endmodule

// File: rtl/cvt_split.sv
module cvt_split
    import cvt_pkg::*;
(
    input  logic [IN_W-1:0] bits_i,
    output split_t          split_o
);
    logic [MAG_IN_W-1:0] mag;

    always_comb begin
        mag           = bits_i[MAG_IN_W-1:0];
        split_o.sign  = bits_i[IN_W-1];
        split_o.ovf   = (mag >= OVF_LIMIT);
        split_o.sub   = (mag < SUB_LIMIT);
        split_o.exp   = mag[MAG_IN_W-1 -: IN_EXP_W];
        split_o.man   = mag[IN_MAN_W-1:0];
    end
endmodule

// File: rtl/cvt_round_norm.sv
module cvt_round_norm
    import cvt_pkg::*;
(
    input  logic [IN_EXP_W-1:0]  exp_i,
    input  logic [IN_MAN_W-1:0]  man_i,
    output logic [OUT_MAG_W-1:0] mag_o
);
    logic [OUT_MAG_W-1:0] kept;
    logic                 guard;
    logic                 sticky;

    always_comb begin
        kept   = {OUT_EXP_W'(exp_i - IN_EXP_W'(REBIAS)),
                  man_i[IN_MAN_W-1 -: OUT_MAN_W]};
        guard  = man_i[DROP_W-1];
        sticky = |man_i[DROP_W-2:0];
    end

    // a fraction overflow carries straight into the exponent field
    cvt_rne_step #(.W(OUT_MAG_W)) rne_i (
        .kept_i    (kept),
        .guard_i   (guard),
        .sticky_i  (sticky),
        .rounded_o (mag_o)
    );
endmodule

// File: rtl/cvt_round_sub.sv
module cvt_round_sub
    import cvt_pkg::*;
(
    input  logic [IN_EXP_W-1:0]  exp_i,
    input  logic [IN_MAN_W-1:0]  man_i,
    output logic [OUT_MAG_W-1:0] mag_o
);
    logic [SIG_W-1:0]     sig;
    logic [SH_W-1:0]      sh;
    logic [SIG_W:0]       one_w;
    logic [SIG_W-1:0]     lo_mask;
    logic [OUT_MAG_W-1:0] kept;
    logic                 guard;
    logic                 sticky;

    always_comb begin
        sig     = {exp_i != '0, man_i};
        sh      = (exp_i > IN_EXP_W'(SUB_BASE)) ? '0
                                                : SH_W'(SUB_BASE) - SH_W'(exp_i);
        one_w   = (SIG_W+1)'(1);
        // whole 2^-9 steps of the value
        kept    = OUT_MAG_W'(sig >> sh);
        // first dropped bit, then everything below it
        guard   = (sh != '0) && (|(sig & (SIG_W'(1) << (sh - SH_W'(1)))));
        lo_mask = SIG_W'((one_w << (sh - SH_W'(1))) - one_w);
        sticky  = (sh > SH_W'(1)) && (|(sig & lo_mask));
    end

    cvt_rne_step #(.W(OUT_MAG_W)) rne_i (
        .kept_i    (kept),
        .guard_i   (guard),
        .sticky_i  (sticky),
        .rounded_o (mag_o)
    );
endmodule

// File: rtl/fp32_to_e4m3_cvt.sv
module fp32_to_e4m3_cvt
    import cvt_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            in_valid_i,
    input  logic [IN_W-1:0] in_bits_i,
    output logic            out_valid_o,
    output logic [OUT_W-1:0] out_bits_o
);
    split_t               split;
    logic [OUT_MAG_W-1:0] norm_mag;
    logic [OUT_MAG_W-1:0] sub_mag;
    logic [OUT_MAG_W-1:0] sel_mag;
    stage_t               stage_d;
    stage_t               stage_q;

    cvt_split split_i (
        .bits_i  (in_bits_i),
        .split_o (split)
    );

    cvt_round_norm norm_i (
        .exp_i (split.exp),
        .man_i (split.man),
        .mag_o (norm_mag)
    );

    cvt_round_sub sub_i (
        .exp_i (split.exp),
        .man_i (split.man),
        .mag_o (sub_mag)
    );

    always_comb begin
        if (split.ovf) begin
            sel_mag = NAN_MAG;
        end else if (split.sub) begin
            sel_mag = sub_mag;
        end else begin
            sel_mag = norm_mag;
        end

        stage_d       = stage_q;
        stage_d.valid = in_valid_i;
        if (in_valid_i) begin
            stage_d.bits = {split.sign, sel_mag};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid_o = stage_q.valid;
    assign out_bits_o  = stage_q.bits;
endmodule

// File: rtl/cvt_chk.sv
module cvt_chk
    import cvt_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             in_valid_i,
    input logic [IN_W-1:0]  in_bits_i,
    input logic             out_valid_o,
    input logic [OUT_W-1:0] out_bits_o
);
    logic [MAG_IN_W-1:0] in_mag;
    assign in_mag = in_bits_i[MAG_IN_W-1:0];

    assert_valid_follows_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        in_valid_i |=> out_valid_o);

    assert_idle_follows_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> !out_valid_o);

    assert_hold_on_idle_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> $stable(out_bits_o));

    assert_sign_copied_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        in_valid_i |=> (out_bits_o[OUT_W-1] == $past(in_bits_i[IN_W-1])));

    assert_large_is_nan_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && in_mag >= OVF_LIMIT) |=> (out_bits_o[OUT_MAG_W-1:0] == NAN_MAG));

    assert_normal_floor_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && in_mag >= SUB_LIMIT && in_mag < OVF_LIMIT)
        |=> (out_bits_o[OUT_MAG_W-1:0] >= OUT_MAG_W'(8)));

    assert_sub_ceiling_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && in_mag < SUB_LIMIT)
        |=> (out_bits_o[OUT_MAG_W-1:0] <= OUT_MAG_W'(8)));

    assert_zero_kept_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && in_mag == '0) |=> (out_bits_o[OUT_MAG_W-1:0] == '0));
endmodule

bind fp32_to_e4m3_cvt cvt_chk chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .in_valid_i  (in_valid_i),
    .in_bits_i   (in_bits_i),
    .out_valid_o (out_valid_o),
    .out_bits_o  (out_bits_o)
);

// File: tb/fp32_to_e4m3_cvt_tb_top.sv
`timescale 1ns/1ps
module fp32_to_e4m3_cvt_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_bits = '0;
    logic        out_valid;
    logic [7:0]  out_bits;

    int checks = 0;
    int errors = 0;
    logic [7:0] held = 8'h00;   // model of the output register

    always #10 clk = ~clk;      // 50 MHz

    fp32_to_e4m3_cvt dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .in_valid_i  (in_valid),
        .in_bits_i   (in_bits),
        .out_valid_o (out_valid),
        .out_bits_o  (out_bits)
    );

    // exact value of an 8-bit code in units of 2^-50; code 0x7F stands for 480
    function automatic longint unsigned code_value(input int c);
        int e = (c >> 3) & 15;
        int m = c & 7;
        if (e == 0) return 64'(m) << 41;
        return 64'(8 + m) << (e + 40);
    endfunction

    // nearest-code search with ties to the even code
    function automatic logic [7:0] ref_cvt(input logic [31:0] x);
        int e = int'(x[30:23]);
        longint unsigned v, d, best_d;
        int best;
        logic [6:0] r;
        if (x[30:0] >= 31'h43F00000) begin
            r = 7'h7F;
        end else if (e < 100) begin
            r = 7'h00;          // far below half of the smallest step
        end else begin
            v = 64'({1'b1, x[22:0]}) << (e - 100);
            best = 0;
            best_d = 64'hFFFF_FFFF_FFFF_FFFF;
            for (int c = 0; c < 128; c++) begin
                d = (v > code_value(c)) ? v - code_value(c) : code_value(c) - v;
                if (d < best_d || (d == best_d && (c % 2) == 0)) begin
                    best_d = d;
                    best = c;
                end
            end
            r = 7'(best);
        end
        return {x[31], r};
    endfunction

    function automatic string range_tag(input logic [31:0] x);
        if (x[30:0] >= 31'h43F00000) return "R2 overflow";
        if (x[30:0] < 31'h3C800000) return "R5 subnormal";
        return "R3 normal";
    endfunction

    task automatic check(input string tag, input logic exp_v, input logic [7:0] exp_b);
        checks++;
        if (out_valid !== exp_v || out_bits !== exp_b) begin
            errors++;
            $display("FAIL %s: in=%08h valid=%0b bits=%02h expected valid=%0b bits=%02h",
                     tag, in_bits, out_valid, out_bits, exp_v, exp_b);
        end
    endtask

    // drive one cycle, then compare one clock later away from the edge
    task automatic apply(input logic v, input logic [31:0] b,
                         input logic [7:0] exp_b, input string tag);
        in_valid = v;
        in_bits  = b;
        @(posedge clk);
        #5;
        if (v) held = exp_b;
        check(v ? tag : {"R7 hold / ", tag}, v, held);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #5;
        held = 8'h00;
        check("R8 reset clears", 1'b0, 8'h00);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stimulus
        logic [31:0] lfsr;
        do_reset();

        // normal range, ties and carries
        apply(1, 32'h3F800000, 8'h38, "R3 one");
        apply(1, 32'h3F880000, 8'h38, "R3 tie down to even");
        apply(1, 32'h3F980000, 8'h3A, "R3 tie up to even");
        apply(1, 32'h43E00000, 8'h7E, "R3 448");
        apply(1, 32'h3C800000, 8'h08, "R3 smallest normal");
        apply(1, 32'h3FF80000, 8'h40, "R4 carry into exponent");
        apply(1, 32'h43E80000, 8'h7E, "R4 464 tie");
        apply(1, 32'h43EB0000, 8'h7F, "R4 470 rounds to 0x7F");
        // sign
        apply(1, 32'hBF800000, 8'hB8, "R1 minus one");
        apply(1, 32'hC3F00000, 8'hFF, "R1 minus 480");
        apply(1, 32'hFF800000, 8'hFF, "R1 minus infinity");
        // overflow
        apply(1, 32'h43F00000, 8'h7F, "R2 480");
        apply(1, 32'h7F800000, 8'h7F, "R2 infinity");
        apply(1, 32'h7FC00000, 8'h7F, "R2 not-a-number");
        apply(1, 32'h70000000, 8'h7F, "R2 huge");
        // subnormal range
        apply(1, 32'h3B000000, 8'h01, "R5 one step");
        apply(1, 32'h3BC00000, 8'h03, "R5 three steps");
        apply(1, 32'h3B400000, 8'h02, "R5 1.5 steps tie");
        apply(1, 32'h3C500000, 8'h06, "R5 6.5 steps tie");
        apply(1, 32'h3C700000, 8'h08, "R5 7.5 steps up to normal");
        // underflow and zeros
        apply(1, 32'h3A800000, 8'h00, "R6 2^-10 tie to zero");
        apply(1, 32'h3A800001, 8'h01, "R6 just above 2^-10");
        apply(1, 32'h00000000, 8'h00, "R6 plus zero");
        apply(1, 32'h80000000, 8'h80, "R6 minus zero");
        apply(1, 32'h00000001, 8'h00, "R6 input subnormal");
        apply(1, 32'h30000000, 8'h00, "R6 tiny");
        // hold on idle cycles
        apply(1, 32'h3F800000, 8'h38, "R7 load");
        apply(0, 32'h43F00000, 8'h00, "R7 idle large");
        apply(0, 32'hBF800000, 8'h00, "R7 idle negative");
        apply(1, 32'h40000000, 8'h40, "R8 strobe after idle");

        // exponent sweep against the reference search
        lfsr = 32'hACE1_2357;
        for (int e = 95; e <= 140; e++) begin
            for (int k = 0; k < 16; k++) begin
                logic [31:0] x;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                x = {lfsr[31], 8'(e), (k < 8) ? {3'(k), 1'b1, 19'h0} : lfsr[22:0]};
                apply(1, x, ref_cvt(x), range_tag(x));
            end
        end

        // random patterns with idle cycles between
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] x;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            x = lfsr;
            if (i % 3 == 0) x[30:27] = 4'b0111;   // bias towards the active range
            apply((i % 5) != 4, x, ref_cvt(x), range_tag(x));
        end

        do_reset();
        apply(1, 32'h3F980000, 8'h3A, "R8 after second reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule